// File: doc/BRIEF.md
# Host Command Channel Sequencer

This block is a single memory-mapped channel through which host software posts one transaction to a downstream serial power-management bus engine and later collects the result. Software writes an optional data word and then a packed command word. The command write launches the transaction. The channel raises a request toward the bus engine and holds it until the engine accepts it. It then waits for a completion pulse.

A write transaction returns to idle as soon as it completes. A read transaction captures the returned bytes and stays parked until software acknowledges them through a valid-clear register. The current state code can always be polled through a status register. Commands that arrive while the channel is busy are dropped and recorded in a sticky error flag.

Top module: `host_cmd_chan`

## Requirements
- R1: After a synchronous active-low reset, the status register reads 0, with idle state code 0 in bits [3:1] and the error flag in bit 0 clear. The read-data and write-data registers read 0, and `req_valid` is low.
- R2: Register offsets are: 0 command word, 1 write data, 2 read data, 3 valid clear, 4 status. A command write in idle moves the state to 1 (request pending) and raises `req_valid`. The request fields come from the command word: type from [31:30], write flag from [29] (1 = write), slave ID from [27:24], byte count minus one from [18:16], and address from [15:0]. Reading offset 0 returns the last accepted command word.
- R3: While `req_valid` is high and `req_ready` is low, the request and all its fields stay unchanged. A cycle with `req_ready` high moves the state to 2 (waiting for completion) and drops `req_valid`.
- R4: A `done` pulse in state 2 for a write command returns the state directly to 0. The read-data register is left unchanged.
- R5: A `done` pulse in state 2 for a read command moves the state to 6 (wait for valid clear). The read-data register then holds `done_rdata` with only the low byte-count bytes kept (little-endian) and the upper bytes zero.
- R6: In state 6, a write to the valid-clear register with bit 0 set returns the state to 0. A write with bit 0 clear leaves the state at 6.
- R7: A command write while the state is not 0 is ignored: the state and the stored command are unchanged. It sets the status error bit 0, which stays set until reset.
- R8: Writes to the write-data register take effect only in idle. `req_wdata` is the write-data register with only the low byte-count bytes kept.
- R9: A `done` pulse outside state 2 changes neither the state nor the read-data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value at `reg_addr` |
| req_valid | output | 1 | Request to bus engine |
| req_ready | input | 1 | Bus engine accepts the request |
| req_type | output | 2 | Command type |
| req_write | output | 1 | 1 = write, 0 = read |
| req_sid | output | 4 | Slave ID |
| req_len | output | 3 | Byte count minus one |
| req_addr | output | 16 | Register address |
| req_wdata | output | 32 | Masked write data |
| done | input | 1 | Completion pulse from bus engine |
| done_rdata | input | 32 | Read data carried with `done` |

## Verification
On every cycle, the assertions check three things. The request stays stable until accepted. Completions route writes to idle and reads to the valid-clear state. The error flag never drops without reset, and the state code always takes one of its four legal values. Only the bench's scenarios can show the rest. These are the field decoding, the byte masking for each length, and that commands, data writes and done pulses arriving at the wrong time leave the registers untouched.

// File: rtl/host_cmd_chan.sv
module host_cmd_chan #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_type,
  output logic              req_write,
  output logic [3:0]        req_sid,
  output logic [2:0]        req_len,
  output logic [15:0]       req_addr,
  output logic [31:0]       req_wdata,
  input  logic              done,
  input  logic [31:0]       done_rdata
);
  localparam int WORD_W = 32;
  localparam int NBYTES = WORD_W / 8;
  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_PEND = 3'd1;
  localparam logic [2:0] ST_WAIT = 3'd2;
  localparam logic [2:0] ST_VCLR = 3'd6;
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_WDATA = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_RDATA = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_VCLR  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(4);

  logic [2:0]        state;
  logic              err;
  logic [WORD_W-1:0] cmd_q, wdata_q, rdata_q, lane_mask;

  wire wr_cmd  = reg_wr && (reg_addr == A_CMD);
  wire wr_wd   = reg_wr && (reg_addr == A_WDATA);
  wire wr_vclr = reg_wr && (reg_addr == A_VCLR);

  always_comb begin
    for (int i = 0; i < NBYTES; i++)
      lane_mask[i*8 +: 8] = (int'(cmd_q[18:16]) >= i) ? 8'hFF : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      err     <= 1'b0;
      cmd_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_cmd) begin
        if (state == ST_IDLE) begin
          cmd_q <= reg_wdata;
          state <= ST_PEND;
        end else begin
          err <= 1'b1;
        end
      end
      if (wr_wd && state == ST_IDLE) wdata_q <= reg_wdata;
      case (state)
        ST_PEND: if (req_ready) state <= ST_WAIT;
        ST_WAIT: if (done) begin
          if (cmd_q[29]) state <= ST_IDLE;
          else begin
            rdata_q <= done_rdata & lane_mask;
            state   <= ST_VCLR;
          end
        end
        ST_VCLR: if (wr_vclr && reg_wdata[0]) state <= ST_IDLE;
        default: ;
      endcase
    end
  end

  assign req_valid = (state == ST_PEND);
  assign req_type  = cmd_q[31:30];
  assign req_write = cmd_q[29];
  assign req_sid   = cmd_q[27:24];
  assign req_len   = cmd_q[18:16];
  assign req_addr  = cmd_q[15:0];
  assign req_wdata = wdata_q & lane_mask;

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = cmd_q;
      A_WDATA: reg_rdata = wdata_q;
      A_RDATA: reg_rdata = rdata_q;
      A_STAT:  reg_rdata = {28'd0, state, err};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/host_cmd_chan_chk.sv
module host_cmd_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  state,
  input logic        err,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_type,
  input logic        req_write,
  input logic [3:0]  req_sid,
  input logic [2:0]  req_len,
  input logic [15:0] req_addr,
  input logic [31:0] req_wdata,
  input logic        done
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_type) && $stable(req_write)
      && $stable(req_sid) && $stable(req_len) && $stable(req_addr) && $stable(req_wdata)); // R3
  AST_ACK_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid && state == 3'd2); // R3
  AST_WR_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd2 && done && req_write |=> state == 3'd0); // R4
  AST_RD_DONE_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd2 && done && !req_write |=> state == 3'd6); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R7
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd0 || state == 3'd1 || state == 3'd2 || state == 3'd6); // R2
endmodule

bind host_cmd_chan host_cmd_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .err(err),
  .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
  .req_write(req_write), .req_sid(req_sid), .req_len(req_len),
  .req_addr(req_addr), .req_wdata(req_wdata), .done(done)
);

// File: tb/test_host_cmd_chan.sv
module test_host_cmd_chan;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;

  logic clk = 0, rst_n = 0, reg_wr = 0, req_ready = 0, done = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, done_rdata = '0, reg_rdata, req_wdata;
  logic req_valid, req_write;
  logic [1:0] req_type;
  logic [3:0] req_sid;
  logic [2:0] req_len;
  logic [15:0] req_addr;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_cmd_chan #(.ADDR_W(AW)) i_host_cmd_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_type(req_type), .req_write(req_write),
    .req_sid(req_sid), .req_len(req_len), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .done_rdata(done_rdata)
  );

  // {command, write data, done data, expected masked word}
  localparam logic [127:0] VEC [6] = '{
    {32'h63000012, 32'hA1B2C3D4, 32'h0,        32'h000000D4},
    {32'hCF03BEEF, 32'h0,        32'h11223344, 32'h11223344},
    {32'h85010100, 32'h0,        32'hDEADBEEF, 32'h0000BEEF},
    {32'h2002FFFF, 32'h55667788, 32'h0,        32'h00667788},
    {32'h49000042, 32'h0,        32'hCAFEF00D, 32'h0000000D},
    {32'hEA031234, 32'h0BADF00D, 32'h0,        32'h0BADF00D}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic ack();
    @(negedge clk); req_ready = 1;
    @(negedge clk); req_ready = 0;
  endtask

  task automatic pulse_done(input logic [31:0] d);
    @(negedge clk); done = 1; done_rdata = d;
    @(negedge clk); done = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, c;
    do_reset();
    rd(3'd4, r); chk("R1 status", r, 32'h0);
    rd(3'd2, r); chk("R1 rdata", r, 32'h0);
    rd(3'd1, r); chk("R1 wdata", r, 32'h0);
    chk("R1 req_valid", {31'd0, req_valid}, 32'h0);

    for (int v = 0; v < 6; v++) begin
      c = VEC[v][127:96];
      wr(3'd1, VEC[v][95:64]);
      wr(3'd0, c);
      rd(3'd4, r); chk("R2 status pend", r, 32'h2);
      chk("R2 req_valid", {31'd0, req_valid}, 32'h1);
      chk("R2 fields", {req_type, req_write, 1'b0, req_sid, 5'd0, req_len, req_addr},
          c & 32'hEF07FFFF);
      rd(3'd0, r); chk("R2 cmd readback", r, c);
      if (c[29]) chk("R8 masked wdata", req_wdata, VEC[v][31:0]);
      ack();
      rd(3'd4, r); chk("R3 status wait", r, 32'h4);
      chk("R3 valid dropped", {31'd0, req_valid}, 32'h0);
      pulse_done(VEC[v][63:32]);
      rd(3'd4, r);
      if (c[29]) chk("R4 write to idle", r, 32'h0);
      else begin
        chk("R5 read parks", r, 32'hC);
        rd(3'd2, r); chk("R5 masked rdata", r, VEC[v][31:0]);
        wr(3'd3, 32'h1);
        rd(3'd4, r); chk("R6 clear to idle", r, 32'h0);
      end
    end

    rd(3'd2, r);
    c = r;
    wr(3'd1, 32'h12345678);
    wr(3'd0, 32'h44300005);
    repeat (3) @(negedge clk);
    chk("R3 held valid", {31'd0, req_valid}, 32'h1);
    chk("R3 held addr", {16'd0, req_addr}, 32'h5);
    pulse_done(32'hFFFFFFFF);
    rd(3'd4, r); chk("R9 done in pend", r, 32'h2);
    rd(3'd2, r); chk("R9 rdata kept", r, c);
    wr(3'd0, 32'hFFFFFFFF);
    rd(3'd4, r); chk("R7 err set", r, 32'h3);
    rd(3'd0, r); chk("R7 cmd kept", r, 32'h44300005);
    wr(3'd1, 32'hFFFFFFFF);
    rd(3'd1, r); chk("R8 busy wdata ignored", r, 32'h12345678);
    ack();
    pulse_done(32'h99887766);
    rd(3'd2, r); chk("R5 one byte", r, 32'h66);
    rd(3'd4, r); chk("R5 park with err", r, 32'hD);
    wr(3'd3, 32'h0);
    rd(3'd4, r); chk("R6 clear bit0 zero", r, 32'hD);
    wr(3'd3, 32'h1);
    rd(3'd4, r); chk("R6 cleared", r, 32'h1);
    pulse_done(32'hFFFFFFFF);
    rd(3'd2, r); chk("R9 done in idle", r, 32'h66);
    rd(3'd4, r); chk("R7 sticky", r, 32'h1);
    do_reset();
    rd(3'd4, r); chk("R1 err cleared", r, 32'h0);
    rd(3'd2, r); chk("R1 rdata cleared", r, 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule